// File: doc/BRIEF.md
# Exception Entry Sequencer

This block performs the status and program-counter update a processor core makes when it takes an exception. A vector of pending causes arrives each cycle. The block resolves it to one cause by a fixed priority. From the chosen cause it derives the target mode, the vector address, the interrupt-mask bits to set and the return-address offset. It also combines the current program counter, the status word and the compressed-instruction flag.

All results are registered. One clock edge after a cause is presented, the block shows the following outputs for exactly one cycle, together with a done pulse:

- the new program counter
- the link value
- the rewritten status word
- the saved copy of the old status
- the target mode

A separate strobe tells the banked register file to swap banks, and only when the mode actually changes. Between entries every result output holds its last value.

Top module: `exc_entry_seq`

## Requirements
- R1: While reset is held and after its release until the first entry, `pc_o` is 0, `status_o` is 32'h0000_01D3 (supervisor mode 5'h13 in bits 4:0, with the A, I and F bits at positions 8, 7 and 6 set), `mode_o` is 5'h13, and `done_o` and `bank_sw_o` are 0.
- R2: A cycle in which `req_i` is nonzero gives `done_o` high for exactly the following cycle. A cycle with `req_i` zero gives `done_o` low in the following cycle.
- R3: `req_i` bits are 0 undefined instruction, 1 software interrupt, 2 prefetch abort, 3 breakpoint, 4 data abort, 5 IRQ, 6 FIQ. When several are set, the winner is data abort, then FIQ, then IRQ, then prefetch abort or breakpoint, then undefined, then software interrupt.
- R4: The vector offset is 0x1C for FIQ, 0x18 for IRQ, 0x10 for data abort, 0x0C for prefetch abort and breakpoint, 0x08 for software interrupt and 0x04 for undefined instruction.
- R5: When `hivec_i` is 1, `pc_o` is 0xFFFF0000 plus the vector offset; otherwise it is the offset alone.
- R6: The target mode is written in `mode_o` and in `status_o[4:0]`. It is 5'h11 for FIQ, 5'h12 for IRQ, 5'h13 for software interrupt, 5'h17 for either abort or breakpoint, and 5'h1B for undefined instruction.
- R7: Entry sets status bits A(8) and I(7) for aborts, breakpoint and IRQ; A, I and F(6) for FIQ; and I alone for undefined and software interrupt. Bits already set stay set.
- R8: `link_o` is `pc_i` plus an offset: 8 for data abort, 0 for software interrupt, 4 for the other causes, except 2 for undefined instruction while `cmp_i` is 1.
- R9: `saved_o` equals the whole `status_i` of the cycle in which the cause was taken.
- R10: `status_o` keeps bits 31:9 of the old status and bits A, I and F unless the mask sets them. It clears bit 5, the compressed-instruction flag.
- R11: While `done_o` is low, `pc_o`, `link_o`, `status_o`, `saved_o` and `mode_o` hold their values.
- R12: `bank_sw_o` is high only together with `done_o`, and only when the target mode differs from `status_i[4:0]` of the cycle the cause was taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| req_i | input | 7 | Pending exception causes, one bit per cause |
| pc_i | input | 32 | Current program counter |
| status_i | input | 32 | Current status word |
| cmp_i | input | 1 | Compressed-instruction state is active |
| hivec_i | input | 1 | Place vectors at the high base |
| pc_o | output | 32 | New program counter (vector address) |
| link_o | output | 32 | Return address for the link register |
| status_o | output | 32 | New status word |
| saved_o | output | 32 | Old status word for the saved-status register |
| mode_o | output | 5 | Mode being entered |
| done_o | output | 1 | Single-cycle entry-complete pulse |
| bank_sw_o | output | 1 | Strobe to swap register banks |

## Verification
The assertions assume that `req_i`, `pc_i`, `status_i`, `cmp_i` and `hivec_i` carry known values at every rising edge once the internal reset has released. They also assume that any mode value, even an unlisted one, may appear in `status_i`. The stimulus changes inputs only on falling edges and holds `req_i` at zero through reset. It covers every single cause, overlapping causes in all priority tiers, both vector bases and both compressed states, as well as an entry taken from the mode it targets. It then adds a long run of arbitrary input words.

// File: rtl/exc_pkg.sv
package exc_pkg;
  localparam int XLEN    = 32;
  localparam int MODE_W  = 5;
  localparam int NUM_REQ = 7;
  localparam int MASK_W  = 3;

  // request vector bit positions
  localparam int RQ_UNDEF = 0;
  localparam int RQ_SWI   = 1;
  localparam int RQ_PABT  = 2;
  localparam int RQ_BKPT  = 3;
  localparam int RQ_DABT  = 4;
  localparam int RQ_IRQ   = 5;
  localparam int RQ_FIQ   = 6;

  // winner first
  localparam int PRIO_ORDER [NUM_REQ] = '{RQ_DABT, RQ_FIQ, RQ_IRQ, RQ_PABT,
                                         RQ_BKPT, RQ_UNDEF, RQ_SWI};

  // status word bit positions
  localparam int ST_CMP = 5;
  localparam int ST_F   = 6;
  localparam int ST_I   = 7;
  localparam int ST_A   = 8;

  localparam logic [MODE_W-1:0] MD_FIQ = 5'h11;
  localparam logic [MODE_W-1:0] MD_IRQ = 5'h12;
  localparam logic [MODE_W-1:0] MD_SVC = 5'h13;
  localparam logic [MODE_W-1:0] MD_ABT = 5'h17;
  localparam logic [MODE_W-1:0] MD_UND = 5'h1B;

  // mask vector order {A, I, F}
  localparam logic [MASK_W-1:0] MK_I   = 3'b010;
  localparam logic [MASK_W-1:0] MK_AI  = 3'b110;
  localparam logic [MASK_W-1:0] MK_AIF = 3'b111;

  // cause code n+1 corresponds to request bit n
  typedef enum logic [2:0] {
    CZ_NONE, CZ_UNDEF, CZ_SWI, CZ_PABT, CZ_BKPT, CZ_DABT, CZ_IRQ, CZ_FIQ
  } cause_e;

  localparam logic [XLEN-1:0] RESET_STATUS =
    XLEN'(MD_SVC) | (XLEN'(1) << ST_A) | (XLEN'(1) << ST_I) | (XLEN'(1) << ST_F);
endpackage

// File: rtl/exc_rst_sync.sv
module exc_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_sync = sync_q[STAGES-1];
endmodule

// File: rtl/exc_prio.sv
module exc_prio
  import exc_pkg::*;
(
  input  logic [NUM_REQ-1:0] req,
  output logic [NUM_REQ-1:0] grant,
  output cause_e             cause,
  output logic               any
);
  logic [NUM_REQ:0] taken;

  assign taken[0] = 1'b0;

  for (genvar g = 0; g < NUM_REQ; g++) begin : g_chain
    assign grant[PRIO_ORDER[g]] = req[PRIO_ORDER[g]] & ~taken[g];
    assign taken[g+1]           = taken[g] | req[PRIO_ORDER[g]];
  end

  assign any = taken[NUM_REQ];

  always_comb begin
    cause = CZ_NONE;
    for (int i = 0; i < NUM_REQ; i++) begin
      if (grant[i]) cause = cause_e'(3'(i + 1));
    end
  end
endmodule

// File: rtl/exc_table.sv
module exc_table
  import exc_pkg::*;
#(
  parameter logic [XLEN-1:0] HIVEC_BASE = 32'hFFFF_0000
) (
  input  cause_e              cause,
  input  logic                cmp,
  input  logic                hivec,
  output logic [MODE_W-1:0]   mode,
  output logic [MASK_W-1:0]   mask,
  output logic [XLEN-1:0]     vector,
  output logic [XLEN-1:0]     link_off
);
  logic [7:0] vec_off;
  logic [3:0] lofs;

  always_comb begin
    mode    = MD_SVC;
    mask    = '0;
    vec_off = 8'h00;
    lofs    = 4'd0;
    unique case (cause)
      CZ_UNDEF: begin
        mode = MD_UND; mask = MK_I; vec_off = 8'h04; lofs = cmp ? 4'd2 : 4'd4;
      end
      CZ_SWI: begin
        mode = MD_SVC; mask = MK_I; vec_off = 8'h08; lofs = 4'd0;
      end
      CZ_PABT, CZ_BKPT: begin
        mode = MD_ABT; mask = MK_AI; vec_off = 8'h0C; lofs = 4'd4;
      end
      CZ_DABT: begin
        mode = MD_ABT; mask = MK_AI; vec_off = 8'h10; lofs = 4'd8;
      end
      CZ_IRQ: begin
        mode = MD_IRQ; mask = MK_AI; vec_off = 8'h18; lofs = 4'd4;
      end
      CZ_FIQ: begin
        mode = MD_FIQ; mask = MK_AIF; vec_off = 8'h1C; lofs = 4'd4;
      end
      default: begin
        mode = MD_SVC;
      end
    endcase
  end

  assign vector   = (hivec ? HIVEC_BASE : '0) + XLEN'(vec_off);
  assign link_off = XLEN'(lofs);
endmodule

// File: rtl/exc_compose.sv
module exc_compose
  import exc_pkg::*;
(
  input  logic [XLEN-1:0]   old_st,
  input  logic [MODE_W-1:0] mode,
  input  logic [MASK_W-1:0] mask,
  output logic [XLEN-1:0]   new_st
);
  always_comb begin
    new_st               = old_st;
    new_st[MODE_W-1:0]   = mode;
    new_st[ST_CMP]       = 1'b0;
    new_st[ST_A]         = old_st[ST_A] | mask[2];
    new_st[ST_I]         = old_st[ST_I] | mask[1];
    new_st[ST_F]         = old_st[ST_F] | mask[0];
  end
endmodule

// File: rtl/exc_entry_seq.sv
module exc_entry_seq
  import exc_pkg::*;
#(
  parameter logic [XLEN-1:0] HIVEC_BASE  = 32'hFFFF_0000,
  parameter int              SYNC_STAGES = 2
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [NUM_REQ-1:0]     req_i,
  input  logic [XLEN-1:0]        pc_i,
  input  logic [XLEN-1:0]        status_i,
  input  logic                   cmp_i,
  input  logic                   hivec_i,
  output logic [XLEN-1:0]        pc_o,
  output logic [XLEN-1:0]        link_o,
  output logic [XLEN-1:0]        status_o,
  output logic [XLEN-1:0]        saved_o,
  output logic [MODE_W-1:0]      mode_o,
  output logic                   done_o,
  output logic                   bank_sw_o
);
  logic                rst_n_s;
  logic [NUM_REQ-1:0]  grant;
  cause_e              cause;
  logic                take;
  logic [MODE_W-1:0]   tgt_mode;
  logic [MASK_W-1:0]   mask;
  logic [XLEN-1:0]     vector, link_off, new_st;

  logic [XLEN-1:0]     pc_q, pc_d, lr_q, lr_d, st_q, st_d, sv_q, sv_d;
  logic [MODE_W-1:0]   md_q, md_d;
  logic                done_q, done_d, sw_q, sw_d;

  exc_rst_sync #(.STAGES(SYNC_STAGES)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_n_sync(rst_n_s)
  );

  exc_prio u_prio (.req(req_i), .grant(grant), .cause(cause), .any(take));

  exc_table #(.HIVEC_BASE(HIVEC_BASE)) u_table (
    .cause(cause), .cmp(cmp_i), .hivec(hivec_i),
    .mode(tgt_mode), .mask(mask), .vector(vector), .link_off(link_off)
  );

  exc_compose u_comp (
    .old_st(status_i), .mode(tgt_mode), .mask(mask), .new_st(new_st)
  );

  // next state
  always_comb begin
    pc_d   = pc_q;
    lr_d   = lr_q;
    st_d   = st_q;
    sv_d   = sv_q;
    md_d   = md_q;
    done_d = take;
    sw_d   = take && (tgt_mode != status_i[MODE_W-1:0]);
    if (take) begin
      pc_d = vector;
      lr_d = pc_i + link_off;
      st_d = new_st;
      sv_d = status_i;
      md_d = tgt_mode;
    end
  end

  // registers
  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) begin
      pc_q   <= '0;
      lr_q   <= '0;
      st_q   <= RESET_STATUS;
      sv_q   <= '0;
      md_q   <= MD_SVC;
      done_q <= 1'b0;
      sw_q   <= 1'b0;
    end else begin
      done_q <= done_d;
      sw_q   <= sw_d;
      if (take) begin
        pc_q <= pc_d;
        lr_q <= lr_d;
        st_q <= st_d;
        sv_q <= sv_d;
        md_q <= md_d;
      end
    end
  end

  assign pc_o      = pc_q;
  assign link_o    = lr_q;
  assign status_o  = st_q;
  assign saved_o   = sv_q;
  assign mode_o    = md_q;
  assign done_o    = done_q;
  assign bank_sw_o = sw_q;

  assert_done_follows_req_R2: assert property (@(posedge clk) disable iff (!rst_n_s)
    (req_i != '0) |=> done_o);
  assert_no_done_idle_R2: assert property (@(posedge clk) disable iff (!rst_n_s)
    (req_i == '0) |=> !done_o);
  assert_single_grant_R3: assert property (@(posedge clk) disable iff (!rst_n_s)
    $onehot0(grant) && ((req_i != '0) == (grant != '0)));
  assert_mode_field_R6: assert property (@(posedge clk) disable iff (!rst_n_s)
    done_o |-> (status_o[MODE_W-1:0] == mode_o));
  assert_irq_masked_R7: assert property (@(posedge clk) disable iff (!rst_n_s)
    done_o |-> status_o[ST_I]);
  assert_saved_copy_R9: assert property (@(posedge clk) disable iff (!rst_n_s)
    (req_i != '0) |=> (saved_o == $past(status_i)));
  assert_cmp_cleared_R10: assert property (@(posedge clk) disable iff (!rst_n_s)
    done_o |-> !status_o[ST_CMP]);
  assert_hold_idle_R11: assert property (@(posedge clk) disable iff (!rst_n_s)
    (req_i == '0) |=> ($stable(pc_o) && $stable(status_o) && $stable(link_o)));
  assert_bank_with_done_R12: assert property (@(posedge clk) disable iff (!rst_n_s)
    bank_sw_o |-> done_o);
endmodule

// File: tb/tb_exc_entry_seq.sv
module tb_exc_entry_seq;
  localparam time CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [6:0]  req;
  logic [31:0] pc, st;
  logic        cmp, hv;
  logic [31:0] pc_o, link_o, status_o, saved_o;
  logic [4:0]  mode_o;
  logic        done_o, bank_sw_o;

  typedef struct {
    logic [31:0] pc, lr, st, sv;
    logic [4:0]  mode;
    logic        sw;
  } exp_t;

  exp_t q[$];
  exp_t last;
  bit   have_last = 0;
  bit   mon_en = 0;
  int   checks = 0;
  int   errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  exc_entry_seq dut (
    .clk(clk), .rst_n(rst_n), .req_i(req), .pc_i(pc), .status_i(st),
    .cmp_i(cmp), .hivec_i(hv), .pc_o(pc_o), .link_o(link_o),
    .status_o(status_o), .saved_o(saved_o), .mode_o(mode_o),
    .done_o(done_o), .bank_sw_o(bank_sw_o)
  );

  task automatic chk(string rq, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", rq, what, act, exp);
    end
  endtask

  // reference from the requirements (R3..R10, R12)
  function automatic exp_t model(logic [6:0] r, logic [31:0] p, logic [31:0] s,
                                 logic c, logic h);
    exp_t e;
    logic [4:0] m; logic [7:0] v; logic a, i, f; logic [31:0] off;
    a = 0; i = 1; f = 0;
    if (r[4])             begin m = 5'h17; v = 8'h10; a = 1; off = 8; end
    else if (r[6])        begin m = 5'h11; v = 8'h1C; a = 1; f = 1; off = 4; end
    else if (r[5])        begin m = 5'h12; v = 8'h18; a = 1; off = 4; end
    else if (r[2] | r[3]) begin m = 5'h17; v = 8'h0C; a = 1; off = 4; end
    else if (r[0])        begin m = 5'h1B; v = 8'h04; off = c ? 2 : 4; end
    else                  begin m = 5'h13; v = 8'h08; off = 0; end
    e.pc   = (h ? 32'hFFFF_0000 : 32'h0) + {24'h0, v};
    e.lr   = p + off;
    e.sv   = s;
    e.st   = {s[31:9], s[8] | a, s[7] | i, s[6] | f, 1'b0, m};
    e.mode = m;
    e.sw   = (m != s[4:0]);
    return e;
  endfunction

  task automatic enter(logic [6:0] r, logic [31:0] p, logic [31:0] s, logic c, logic h);
    @(negedge clk);
    req = r; pc = p; st = s; cmp = c; hv = h;
    if (r != 0) q.push_back(model(r, p, s, c, h));
  endtask

  task automatic idle(int n);
    repeat (n) begin
      @(negedge clk);
      req = '0;
    end
  endtask

  // monitor / scoreboard
  initial begin
    wait (mon_en);
    forever begin
      @(posedge clk);
      #1;
      if (done_o) begin
        if (q.size() == 0) begin
          chk("R2", "done without request", 32'(done_o), 32'h0);
        end else begin
          exp_t e;
          e = q.pop_front();
          chk("R2", "done pulse", 32'(done_o), 32'h1);
          chk("R4/R5", "vector pc", pc_o, e.pc);
          chk("R8", "link", link_o, e.lr);
          chk("R7/R10", "status", status_o, e.st);
          chk("R9", "saved status", saved_o, e.sv);
          chk("R6", "mode", 32'(mode_o), 32'(e.mode));
          chk("R12", "bank strobe", 32'(bank_sw_o), 32'(e.sw));
          last = e;
          have_last = 1;
        end
      end else if (have_last) begin
        chk("R11", "pc hold", pc_o, last.pc);
        chk("R11", "status hold", status_o, last.st);
        chk("R11", "link hold", link_o, last.lr);
        chk("R12", "no strobe when idle", 32'(bank_sw_o), 32'h0);
      end
    end
  end

  initial begin
    #(CLK_PERIOD * 50000);
    errors++;
    $display("FAIL watchdog: actual running expected finished");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    req = '0; pc = '0; st = 32'h10; cmp = 0; hv = 0;
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    repeat (4) @(posedge clk);
    #1;
    chk("R1", "reset pc", pc_o, 32'h0);
    chk("R1", "reset status", status_o, 32'h0000_01D3);
    chk("R1", "reset mode", 32'(mode_o), 32'h13);
    chk("R1", "reset done", 32'(done_o), 32'h0);
    chk("R1", "reset strobe", 32'(bank_sw_o), 32'h0);
    mon_en = 1;

    // each cause alone, low vectors (R4, R6, R7, R8)
    for (int b = 0; b < 7; b++) begin
      enter(7'(1 << b), 32'h0000_1000, 32'h0000_0010, 1'b0, 1'b0);
      idle(2);
    end
    // compressed state: undefined gets 2, swi stays 0 (R8)
    enter(7'h01, 32'h0000_2002, 32'h0000_0030, 1'b1, 1'b0); idle(1);
    enter(7'h02, 32'h0000_2002, 32'h0000_0030, 1'b1, 1'b0); idle(1);
    enter(7'h10, 32'h0000_2002, 32'h0000_0030, 1'b1, 1'b0); idle(1);
    // high vectors (R5)
    for (int b = 0; b < 7; b++) begin
      enter(7'(1 << b), 32'h8000_0000, 32'h0000_001F, 1'b0, 1'b1);
      idle(1);
    end
    // priority tiers (R3)
    enter(7'h7F, 32'h100, 32'h10, 0, 0); idle(1);
    enter(7'h6F, 32'h100, 32'h10, 0, 0); idle(1);
    enter(7'h2F, 32'h100, 32'h10, 0, 0); idle(1);
    enter(7'h0F, 32'h100, 32'h10, 0, 0); idle(1);
    enter(7'h03, 32'h100, 32'h10, 0, 0); idle(1);
    // upper bits kept, mask bits kept, compressed bit cleared (R10)
    enter(7'h01, 32'hABCD_0000, 32'hF000_01F0, 1'b1, 1'b0); idle(1);
    // entry from the target mode: no bank swap (R12)
    enter(7'h10, 32'h400, 32'h0000_0117, 1'b0, 1'b0); idle(1);
    enter(7'h40, 32'h400, 32'h0000_01D1, 1'b0, 1'b0); idle(1);
    // back to back (R2)
    enter(7'h20, 32'h10, 32'h10, 0, 0);
    enter(7'h40, 32'h20, 32'h12, 0, 1);
    enter(7'h02, 32'h30, 32'h11, 1, 0);
    idle(3);
    // arbitrary words
    for (int n = 0; n < 400; n++) begin
      enter(7'($urandom), $urandom, $urandom, 1'($urandom), 1'($urandom));
      if ((n % 3) == 0) idle(1);
    end
    idle(4);
    wait (q.size() == 0);
    @(posedge clk);
    #2;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule